// File: doc/BRIEF.md
# Three-wire serial EEPROM slave

This block models the slave side of a small serial EEPROM that a host drives over three wires: a chip select, a shift clock and a serial data input. A fourth pin carries serial output back to the host. All four pins are sampled on the system clock `clk`. The shift clock is assumed to be much slower than `clk`. The output pin is split into a data bit and an output enable, so an enclosing pad can tri-state it. The storage is a register array of 64 words of 16 bits. A static organisation input picks how the host addresses it: either 64 sixteen-bit words or 128 bytes.

Every command frame starts when chip select rises. The frame is a start bit, a two-bit opcode and an address field. Write-type frames then carry a data field. Reads return a leading zero and then the stored word, most significant bit first. The programming commands are write, erase, write-all and erase-all. They only take effect while a program-enable latch is set, and two dedicated commands set and clear that latch. Each accepted programming command starts a self-timed busy period of `WP_CYCLES` clocks. While that period runs, the host can poll a ready/busy flag on the output pin by toggling chip select.

Top module: `eep3w_slave`

## Requirements
- R1: After reset the output enable is low, the program-enable latch is clear and every bit of the array reads as 1.
- R2: A frame opens on a rising edge of `cs`. If the first bit sampled on a rising `sk` is 0, the whole frame is ignored until `cs` falls: no output is driven and nothing is stored. While `cs` is low, `dout_oe` is low.
- R3: Opcode 10 reads. On the `sk` rising edge that samples the last address bit, `dout_oe` goes high and `dout` shows a dummy 0. Each later `sk` rise then presents the next bit of the addressed word, MSB first. Reads work whether or not programming is enabled.
- R4: With `org16`=1, addresses are 6 bits and data is 16 bits. With `org16`=0, addresses are 7 bits and data is 8 bits. In that byte mode, address bits [6:1] select the word and bit 0 selects the upper byte (1) or the lower byte (0).
- R5: For opcode 00, the two most significant address bits select the command: 11 enables programming, 00 disables it, 10 erases all, and 01 writes all. The remaining address bits are still clocked in but ignored.
- R6: Write, erase, write-all and erase-all have no effect, and start no busy period, unless the program-enable latch is set. The latch stays set until the disable command.
- R7: Opcode 01 stores the shifted-in data at the address. Write-all stores it to every location; in byte mode both bytes of every word get the byte.
- R8: Opcode 11 sets every bit of the addressed location to 1. Erase-all sets the whole array to 1.
- R9: The busy period lasts `WP_CYCLES` clocks. For write and write-all it starts after the last data bit; for erase and erase-all it starts after the last address bit. Any frame whose `cs` rise falls within the busy period is ignored entirely.
- R10: If `cs` rises while busy, `dout_oe` goes high and `dout` shows 0 while busy and 1 once the period ends. If `cs` rises when not busy, no status is shown and `dout_oe` stays low until a read phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, high selects |
| sk | input | 1 | Serial shift clock, sampled on `clk` |
| di | input | 1 | Serial data in, taken on rising `sk` |
| org16 | input | 1 | 1 = 16-bit words, 0 = bytes |
| dout | output | 1 | Serial data / ready-busy flag |
| dout_oe | output | 1 | Output enable for `dout` |

## Verification
Each fault class shows up at the pins within one frame of its cause.
- A lost program-enable latch shows up at the next read-back: the word still holds its old value after a write.
- A miscounted bit counter shifts every read bit by one position, which the dummy-zero check catches on the first data bit.
- A busy timer that is too short or too long flips the polled ready/busy flag at the wrong time.
- A control path that accepts frames while busy corrupts the word, and the read after the period ends exposes it.

// File: rtl/eep3w_pkg.sv
package eep3w_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_OP,
        S_ADDR,
        S_DATA,
        S_READ,
        S_STAT,
        S_DONE
    } state_e;

    // two-bit opcode values
    localparam logic [1:0] OP_EXT   = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_ERASE = 2'b11;

    // sub-command held in the top two address bits of opcode 00
    localparam logic [1:0] EXT_DIS   = 2'b00;
    localparam logic [1:0] EXT_WRALL = 2'b01;
    localparam logic [1:0] EXT_ERALL = 2'b10;
    localparam logic [1:0] EXT_EN    = 2'b11;

endpackage

// File: rtl/eep3w_edge.sv
module eep3w_edge #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level;
    end

    assign rise = level & ~prev_q;
endmodule

// File: rtl/eep3w_timer.sv
module eep3w_timer #(
    parameter int unsigned CYCLES = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int unsigned CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)              cnt_d = CW'(CYCLES);
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/eep3w_array.sv
module eep3w_array #(
    parameter int unsigned AW = 6,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          fill,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] wmask,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned WORDS = 1 << AW;

    logic [DW-1:0] mem_q [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic          hit;
        logic [DW-1:0] word_d;

        assign hit    = fill | (we & (waddr == AW'(g)));
        assign word_d = (mem_q[g] & ~wmask) | (wdata & wmask);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   mem_q[g] <= '1;
            else if (hit) mem_q[g] <= word_d;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/eep3w_slave.sv
module eep3w_slave
    import eep3w_pkg::*;
#(
    parameter int unsigned WORD_AW   = 6,
    parameter int unsigned WORD_DW   = 16,
    parameter int unsigned WP_CYCLES = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    input  logic org16,
    output logic dout,
    output logic dout_oe
);
    localparam int unsigned BYTE_AW = WORD_AW + 1;
    localparam int unsigned BYTE_DW = WORD_DW / 2;
    localparam int unsigned CW      = $clog2(WORD_DW + BYTE_AW + 1);

    typedef struct packed {
        state_e               st;
        logic [1:0]           op;
        logic [BYTE_AW-1:0]   addr;
        logic [WORD_DW-1:0]   sr;
        logic [CW-1:0]        cnt;
        logic                 wen;
        logic                 dout;
        logic                 oe;
    } ctl_t;

    ctl_t q, d;

    logic [1:0]         rises;
    logic               cs_rise, sk_rise;
    logic               busy, tstart;
    logic               mem_we, mem_fill;
    logic [WORD_AW-1:0] wr_word, raddr;
    logic [WORD_DW-1:0] wr_data, wr_mask, rdata, read_word;
    logic [BYTE_AW-1:0] addr_sh;
    logic [WORD_DW-1:0] data_sh;
    logic [1:0]         ext_sel;
    logic [CW-1:0]      alen_m1, dlen_m1;
    logic               wen_now;

    function automatic logic [WORD_AW-1:0] word_of(input logic [BYTE_AW-1:0] a,
                                                   input logic x16);
        return x16 ? a[WORD_AW-1:0] : a[BYTE_AW-1:1];
    endfunction

    function automatic logic [WORD_DW-1:0] mask_of(input logic hi, input logic x16);
        if (x16) return '1;
        return hi ? {{BYTE_DW{1'b1}}, {BYTE_DW{1'b0}}}
                  : {{BYTE_DW{1'b0}}, {BYTE_DW{1'b1}}};
    endfunction

    eep3w_edge #(.N(2)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level ({cs, sk}),
        .rise  (rises)
    );
    assign cs_rise = rises[1];
    assign sk_rise = rises[0];

    eep3w_timer #(.CYCLES(WP_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tstart),
        .busy  (busy)
    );

    eep3w_array #(.AW(WORD_AW), .DW(WORD_DW)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .fill  (mem_fill),
        .waddr (wr_word),
        .wdata (wr_data),
        .wmask (wr_mask),
        .raddr (raddr),
        .rdata (rdata)
    );

    // serial views of the incoming bit appended to the held fields
    assign addr_sh = {q.addr[BYTE_AW-2:0], di};
    assign data_sh = {q.sr[WORD_DW-2:0], di};
    assign alen_m1 = org16 ? CW'(WORD_AW - 1) : CW'(BYTE_AW - 1);
    assign dlen_m1 = org16 ? CW'(WORD_DW - 1) : CW'(BYTE_DW - 1);
    assign ext_sel = org16 ? addr_sh[WORD_AW-1 -: 2] : addr_sh[BYTE_AW-1 -: 2];
    assign raddr   = word_of(addr_sh, org16);
    assign read_word = org16 ? rdata
                     : {(addr_sh[0] ? rdata[WORD_DW-1 -: BYTE_DW] : rdata[BYTE_DW-1:0]),
                        {BYTE_DW{1'b0}}};

    always_comb begin
        d        = q;
        tstart   = 1'b0;
        mem_we   = 1'b0;
        mem_fill = 1'b0;
        wr_word  = '0;
        wr_data  = '0;
        wr_mask  = '0;

        if (!cs) begin
            d.st   = S_IDLE;
            d.oe   = 1'b0;
            d.dout = 1'b0;
        end else if (cs_rise) begin
            d.addr = '0;
            d.sr   = '0;
            d.op   = '0;
            d.cnt  = '0;
            d.dout = 1'b0;
            if (busy) begin
                d.st = S_STAT;
                d.oe = 1'b1;
            end else begin
                d.st = S_START;
                d.oe = 1'b0;
            end
        end else if (sk_rise) begin
            case (q.st)
                S_START: d.st = di ? S_OP : S_DONE;

                S_OP: begin
                    d.op = {q.op[0], di};
                    if (q.cnt == CW'(1)) begin
                        d.st  = S_ADDR;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end

                S_ADDR: begin
                    d.addr = addr_sh;
                    if (q.cnt == alen_m1) begin
                        d.cnt = '0;
                        d.st  = S_DONE;
                        case (q.op)
                            OP_READ: begin
                                d.st   = S_READ;
                                d.oe   = 1'b1;
                                d.dout = 1'b0;
                                d.sr   = read_word;
                            end
                            OP_WRITE: d.st = S_DATA;
                            OP_ERASE: begin
                                if (q.wen) begin
                                    mem_we  = 1'b1;
                                    wr_word = word_of(addr_sh, org16);
                                    wr_data = '1;
                                    wr_mask = mask_of(addr_sh[0], org16);
                                    tstart  = 1'b1;
                                end
                            end
                            default: begin
                                case (ext_sel)
                                    EXT_EN:  d.wen = 1'b1;
                                    EXT_DIS: d.wen = 1'b0;
                                    EXT_ERALL: begin
                                        if (q.wen) begin
                                            mem_fill = 1'b1;
                                            wr_data  = '1;
                                            wr_mask  = '1;
                                            tstart   = 1'b1;
                                        end
                                    end
                                    default: d.st = S_DATA;
                                endcase
                            end
                        endcase
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end

                S_DATA: begin
                    d.sr = data_sh;
                    if (q.cnt == dlen_m1) begin
                        d.st  = S_DONE;
                        d.cnt = '0;
                        if (q.wen) begin
                            tstart  = 1'b1;
                            wr_data = org16 ? data_sh : {2{data_sh[BYTE_DW-1:0]}};
                            if (q.op == OP_WRITE) begin
                                mem_we  = 1'b1;
                                wr_word = word_of(q.addr, org16);
                                wr_mask = mask_of(q.addr[0], org16);
                            end else begin
                                mem_fill = 1'b1;
                                wr_mask  = '1;
                            end
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end

                S_READ: begin
                    if (q.cnt <= dlen_m1) begin
                        d.dout = q.sr[WORD_DW-1];
                        d.sr   = {q.sr[WORD_DW-2:0], 1'b0};
                        d.cnt  = q.cnt + 1'b1;
                    end
                end

                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wen_now = q.wen;
    assign dout    = (q.st == S_STAT) ? ~busy : q.dout;
    assign dout_oe = q.oe;
endmodule

// File: rtl/eep3w_checker.sv
module eep3w_checker (
    input logic clk,
    input logic rst_n,
    input logic cs,
    input logic dout_oe,
    input logic busy,
    input logic tstart,
    input logic wen_now,
    input logic mem_we,
    input logic mem_fill
);
    // R2: deselect always releases the output
    a_r2_cs_low_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> !dout_oe);

    // R2: output only turns on for a selected frame
    a_r2_oe_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_oe) |-> $past(cs));

    // R6: a busy period is only launched with programming enabled
    a_r6_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        tstart |-> wen_now);

    // R9: no new programming cycle while one is running
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !tstart);

    // R7: the array is only modified when idle
    a_r7_store_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_fill) |-> !busy);

    // R8: single-location and whole-array updates never coincide
    a_r8_one_store_kind: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, mem_fill}));
endmodule

bind eep3w_slave eep3w_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs       (cs),
    .dout_oe  (dout_oe),
    .busy     (busy),
    .tstart   (tstart),
    .wen_now  (wen_now),
    .mem_we   (mem_we),
    .mem_fill (mem_fill)
);

// File: tb/eep3w_slave_tb.sv
module eep3w_slave_tb;
    localparam int WP = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0, org16 = 1'b1;
    logic dout, dout_oe;

    always #5 clk = ~clk;

    eep3w_slave #(.WORD_AW(6), .WORD_DW(16), .WP_CYCLES(WP)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
        .org16(org16), .dout(dout), .dout_oe(dout_oe)
    );

    typedef struct {
        logic  oe;
        logic  val;
        string req;
    } exp_t;

    exp_t exq[$];
    event smp_ev;
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;

    // scoreboard monitor
    initial begin
        forever begin
            @(smp_ev);
            while (exq.size() > 0) begin
                exp_t e;
                e = exq.pop_front();
                checks++;
                if (dout_oe !== e.oe || (e.oe && dout !== e.val)) begin
                    fails++;
                    $display("FAIL %s: actual oe=%b dout=%b expected oe=%b dout=%b",
                             e.req, dout_oe, dout, e.oe, e.val);
                end
            end
        end
    end

    task automatic expect_do(input logic oe, input logic val, input string req);
        exp_t e;
        e.oe = oe; e.val = val; e.req = req;
        exq.push_back(e);
        -> smp_ev;
        #1;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        di = b;  tick(3);
        sk = 1'b1; tick(3);
        sk = 1'b0; tick(2);
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    function automatic int alen();
        return org16 ? 6 : 7;
    endfunction

    function automatic int dlen();
        return org16 ? 16 : 8;
    endfunction

    task automatic cs_up();
        cs = 1'b1; tick(3);
    endtask

    task automatic cs_dn();
        cs = 1'b0; di = 1'b0; tick(3);
    endtask

    task automatic frame(input logic [1:0] op, input logic [31:0] addr);
        cs_up();
        send_bit(1'b1);
        send_bits({30'b0, op}, 2);
        send_bits(addr, alen());
    endtask

    task automatic do_read(input logic [31:0] addr, input logic [15:0] exp, input string req);
        frame(2'b10, addr);
        expect_do(1'b1, 1'b0, req);          // dummy zero
        for (int i = dlen() - 1; i >= 0; i--) begin
            send_bit(1'b0);
            expect_do(1'b1, exp[i], req);
        end
        cs_dn();
    endtask

    task automatic do_write(input logic [31:0] addr, input logic [31:0] data);
        frame(2'b01, addr);
        send_bits(data, dlen());
        cs_dn();
    endtask

    task automatic do_ext(input logic [1:0] sel);
        frame(2'b00, 32'(sel) << (alen() - 2));
        cs_dn();
    endtask

    task automatic do_wral(input logic [31:0] data);
        frame(2'b00, 32'(2'b01) << (alen() - 2));
        send_bits(data, dlen());
        cs_dn();
    endtask

    task automatic wait_ready();
        tick(WP + 20);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R9 watchdog: actual=hung expected=complete");
            finish_run();
        end
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(2);
        expect_do(1'b0, 1'b0, "R1 reset oe");
        do_read(5, 16'hFFFF, "R1 array reset ones");

        // R6: write with programming disabled
        do_write(5, 16'h1234);
        cs_up();
        expect_do(1'b0, 1'b0, "R6 no busy when disabled");
        cs_dn();
        do_read(5, 16'hFFFF, "R6 write ignored when disabled");

        // R5 enable, R7 write, R10 polling, R9 length
        do_ext(2'b11);
        do_write(5, 16'hA5C3);
        cs_up();
        expect_do(1'b1, 1'b0, "R10 busy flag");
        tick(WP - 40);
        expect_do(1'b1, 1'b0, "R9 still busy near end");
        tick(60);
        expect_do(1'b1, 1'b1, "R10 ready flag");
        cs_dn();
        do_read(5, 16'hA5C3, "R7 write word");
        do_read(4, 16'hFFFF, "R7 neighbour untouched");

        // R4 byte organisation
        org16 = 1'b0;
        do_read(10, 16'h00C3, "R4 lower byte");
        do_read(11, 16'h00A5, "R4 upper byte");
        do_write(11, 8'h3C);
        wait_ready();
        org16 = 1'b1;
        do_read(5, 16'h3CC3, "R4 byte write merges");

        // R8 erase one word
        do_erase_word: begin
            frame(2'b11, 5);
            cs_dn();
        end
        wait_ready();
        do_read(5, 16'hFFFF, "R8 erase word");

        // R7 write all, both organisations
        do_wral(16'h1234);
        wait_ready();
        do_read(0, 16'h1234, "R7 write all low");
        do_read(63, 16'h1234, "R7 write all high");
        org16 = 1'b0;
        do_wral(8'h5A);
        wait_ready();
        org16 = 1'b1;
        do_read(9, 16'h5A5A, "R7 R4 byte write all");

        // R5 erase all
        do_ext(2'b10);
        wait_ready();
        do_read(0, 16'hFFFF, "R8 erase all");
        do_read(40, 16'hFFFF, "R8 erase all other");

        // R9 frames during busy are ignored
        do_write(7, 16'hAAAA);
        cs_up();
        send_bit(1'b1);
        send_bits(32'b01, 2);
        send_bits(7, 6);
        send_bits(16'h5555, 16);
        expect_do(1'b1, 1'b0, "R9 busy frame stays in status");
        cs_dn();
        wait_ready();
        do_read(7, 16'hAAAA, "R9 busy frame ignored");

        // R10 no status after the period ended
        cs_up();
        expect_do(1'b0, 1'b0, "R10 no status when idle");
        cs_dn();

        // R2 bad start bit
        cs_up();
        send_bit(1'b0);
        send_bits(32'b110, 3);
        send_bits(7, 6);
        send_bits(16'hFFFF, 16);
        expect_do(1'b0, 1'b0, "R2 bad start ignored");
        cs_dn();
        expect_do(1'b0, 1'b0, "R2 cs low releases");
        do_read(7, 16'hAAAA, "R2 bad start stored nothing");

        // R5 disable, R6 writes blocked again, R3 read still works
        do_ext(2'b00);
        do_write(7, 16'h0000);
        wait_ready();
        do_read(7, 16'hAAAA, "R6 R3 read while disabled");

        done = 1'b1;
        tick(2);
        finish_run();
    end
endmodule